// File: doc/BRIEF.md
# Region-of-Interest Readout Flag Generator

This block decides how hard each calorimeter tower's readout unit is suppressed. It takes the transverse energy of every tower in a small rectangular grid, with rows along η and columns along φ. Two programmable thresholds place each tower in one of three interest classes: low, medium or high. A high-interest tower then pulls its whole 3×3 neighbourhood up to minimal-threshold readout.

A medium tower gets minimal-threshold readout for itself only. Any other tower is either skipped at full granularity or read with severe suppression, as a configuration bit selects.

A single `start_i` strobe captures the energies, the thresholds and the severity bit. Two clock edges later `done_o` pulses. The per-tower class words and readout flags then hold until the next strobe. Rows never wrap. Columns wrap around when the `PHI_WRAP` parameter is set, so the first and last φ columns are neighbours.

Top module: `rof_flag_gen`

## Requirements
- R1: A tower whose energy is strictly greater than `thr_hi_i` is classified high (class code 2'b10).
- R2: A tower whose energy is strictly greater than `thr_lo_i` and not greater than `thr_hi_i` is classified medium (class code 2'b01). An energy equal to `thr_hi_i` is therefore medium.
- R3: A tower whose energy is not greater than `thr_lo_i` is classified low (class code 2'b00). An energy equal to `thr_lo_i` is therefore low.
- R4: Each tower has a 3-bit class word. Tower t = row·PHI_N + column occupies `class_o[3t+2:3t]`. Bits [1:0] hold the class code, bit 2 is a reserved bit that reads 0, and code 2'b11 never appears.
- R5: A tower gets flag 2'b11 when any tower in the 3×3 block centred on it, itself included, is high. Tower t's flag occupies `flag_o[2t+1:2t]`.
- R6: A medium tower with no high tower in its 3×3 block gets flag 2'b10.
- R7: A low tower with no high tower in its 3×3 block gets flag 2'b01 if `severe_en_i` was 1 at the strobe, and flag 2'b00 otherwise.
- R8: Positions outside the grid along the row (η) direction count as low. A high tower in row 0 does not raise the flag of any tower in the last row.
- R9: With PHI_WRAP=1, column 0 and column PHI_N−1 are neighbours. A high tower in column 0 raises towers in the adjacent rows of the last column to flag 2'b11.
- R10: After reset, `done_o`, `class_o` and `flag_o` are all zero. When `start_i` is sampled high at a clock edge, `done_o` is high for exactly the cycle following the next edge, and the new classes and flags are valid while it is high.
- R11: Energies, thresholds and `severe_en_i` are sampled only at a strobe. With no strobe, changes on these inputs leave `class_o`, `flag_o` and `done_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture strobe for energies, thresholds and severity bit |
| energy_i | input | ETA_N·PHI_N·EW | Tower energies; tower t at bits [EW·t+EW−1:EW·t] |
| thr_lo_i | input | EW | Lower classification threshold |
| thr_hi_i | input | EW | Higher classification threshold |
| severe_en_i | input | 1 | 1: isolated low towers get severe suppression; 0: they are not read |
| class_o | output | 3·ETA_N·PHI_N | Per-tower class word {reserved, class} |
| flag_o | output | 2·ETA_N·PHI_N | Per-tower readout flag |
| done_o | output | 1 | One-cycle pulse marking valid results |

## Verification
The hardest case to reach is the seam of the grid. A high tower on the first or last column must reach across the φ wrap, but must not reach across the η border. The same tower also sits at an edge, where missing neighbours must count as low. Random energy patterns seldom put a lone high tower exactly there. Directed frames therefore place one high tower at row 0, column 0 on an otherwise quiet grid, and check the last column and the last row separately. Energies set exactly equal to each threshold cover the class boundaries. An all-low frame is applied once with the severity bit set and once with it clear.

// File: rtl/rof_pkg.sv
package rof_pkg;
  typedef enum logic [1:0] {
    CLS_LOW  = 2'b00,
    CLS_MED  = 2'b01,
    CLS_HIGH = 2'b10
  } cls_e;

  typedef enum logic [1:0] {
    FLG_SKIP   = 2'b00,
    FLG_SEVERE = 2'b01,
    FLG_OWN    = 2'b10,
    FLG_ZONE   = 2'b11
  } flg_e;

  localparam int CLS_W = 2;
  localparam int FLG_W = 2;
endpackage

// File: rtl/rof_classify.sv
module rof_classify
  import rof_pkg::*;
#(
  parameter int N  = 32,
  parameter int EW = 10
) (
  input  logic [N*EW-1:0]    energy_i,
  input  logic [EW-1:0]      thr_lo_i,
  input  logic [EW-1:0]      thr_hi_i,
  output logic [N*CLS_W-1:0] cls_o
);
  for (genvar t = 0; t < N; t++) begin : g_twr
    logic [EW-1:0] e;
    assign e = energy_i[t*EW +: EW];
    // equality falls into the lower class
    assign cls_o[t*CLS_W +: CLS_W] = (e > thr_hi_i) ? CLS_HIGH :
                                     (e > thr_lo_i) ? CLS_MED  : CLS_LOW;
  end
endmodule

// File: rtl/rof_dilate.sv
module rof_dilate #(
  parameter int ETA_N    = 4,
  parameter int PHI_N    = 8,
  parameter bit PHI_WRAP = 1'b1
) (
  input  logic [ETA_N*PHI_N-1:0] hi_i,
  output logic [ETA_N*PHI_N-1:0] zone_o
);
  localparam int N = ETA_N * PHI_N;

  function automatic logic zone_hit(input logic [N-1:0] m, input int r, input int c);
    logic h;
    int   rr;
    int   cc;
    h = 1'b0;
    for (int dr = -1; dr <= 1; dr++) begin
      for (int dc = -1; dc <= 1; dc++) begin
        rr = r + dr;
        cc = c + dc;
        if (PHI_WRAP) cc = (cc + PHI_N) % PHI_N;
        if (rr >= 0 && rr < ETA_N && cc >= 0 && cc < PHI_N)
          h = h | m[rr*PHI_N + cc];
      end
    end
    return h;
  endfunction

  for (genvar r = 0; r < ETA_N; r++) begin : g_row
    for (genvar c = 0; c < PHI_N; c++) begin : g_col
      assign zone_o[r*PHI_N + c] = zone_hit(hi_i, r, c);
    end
  end
endmodule

// File: rtl/rof_flag_enc.sv
module rof_flag_enc
  import rof_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N*CLS_W-1:0] cls_i,
  input  logic [N-1:0]       zone_i,
  input  logic               severe_i,
  output logic [N*FLG_W-1:0] flag_o
);
  for (genvar t = 0; t < N; t++) begin : g_twr
    logic [CLS_W-1:0] c;
    assign c = cls_i[t*CLS_W +: CLS_W];
    assign flag_o[t*FLG_W +: FLG_W] = zone_i[t]       ? FLG_ZONE   :
                                      (c == CLS_MED)  ? FLG_OWN    :
                                      severe_i        ? FLG_SEVERE : FLG_SKIP;
  end
endmodule

// File: rtl/rof_flag_gen.sv
module rof_flag_gen
  import rof_pkg::*;
#(
  parameter int ETA_N    = 4,
  parameter int PHI_N    = 8,
  parameter int EW       = 10,
  parameter bit PHI_WRAP = 1'b1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic [ETA_N*PHI_N*EW-1:0]      energy_i,
  input  logic [EW-1:0]                  thr_lo_i,
  input  logic [EW-1:0]                  thr_hi_i,
  input  logic                           severe_en_i,
  output logic [ETA_N*PHI_N*(CLS_W+1)-1:0] class_o,
  output logic [ETA_N*PHI_N*FLG_W-1:0]   flag_o,
  output logic                           done_o
);
  localparam int N  = ETA_N * PHI_N;
  localparam int CW = CLS_W + 1;

  logic [N*CLS_W-1:0] cls_d, cls_q;
  logic [N*FLG_W-1:0] flg_d, flg_q;
  logic [N-1:0]       hi_m, zone;
  logic               sev_q, v1_q, done_q;

  rof_classify #(.N(N), .EW(EW)) u_cls (
    .energy_i (energy_i),
    .thr_lo_i (thr_lo_i),
    .thr_hi_i (thr_hi_i),
    .cls_o    (cls_d)
  );

  // stage 1: classes captured on the strobe; stage 2: flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_q  <= '0;
      sev_q  <= 1'b0;
      v1_q   <= 1'b0;
      flg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      v1_q   <= start_i;
      done_q <= v1_q;
      if (start_i) begin
        cls_q <= cls_d;
        sev_q <= severe_en_i;
      end
      if (v1_q) flg_q <= flg_d;
    end
  end

  for (genvar t = 0; t < N; t++) begin : g_twr
    assign hi_m[t]            = (cls_q[t*CLS_W +: CLS_W] == CLS_HIGH);
    assign class_o[t*CW +: CW] = {1'b0, cls_q[t*CLS_W +: CLS_W]};
  end

  rof_dilate #(.ETA_N(ETA_N), .PHI_N(PHI_N), .PHI_WRAP(PHI_WRAP)) u_dil (
    .hi_i   (hi_m),
    .zone_o (zone)
  );

  rof_flag_enc #(.N(N)) u_enc (
    .cls_i    (cls_q),
    .zone_i   (zone),
    .severe_i (sev_q),
    .flag_o   (flg_d)
  );

  assign flag_o = flg_q;
  assign done_o = done_q;
endmodule

// File: rtl/rof_flag_gen_chk.sv
module rof_flag_gen_chk #(
  parameter int N = 32
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic [N*3-1:0] class_o,
  input logic [N*2-1:0] flag_o,
  input logic           done_o
);
  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ##1 done_o); // R10
  AST_DONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(start_i, 2)); // R10
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(start_i, 2) |-> $stable(flag_o)); // R11
  AST_CLASS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(start_i) |-> $stable(class_o)); // R11

  for (genvar t = 0; t < N; t++) begin : g_twr
    AST_HIGH_ZONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o && class_o[3*t +: 2] == 2'b10 |-> flag_o[2*t +: 2] == 2'b11); // R5
    AST_MED_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o && class_o[3*t +: 2] == 2'b01 |-> flag_o[2*t+1]); // R6
    AST_UNREAD_IS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o && !flag_o[2*t+1] |-> class_o[3*t +: 2] == 2'b00); // R7
    AST_CLASS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> class_o[3*t +: 2] != 2'b11 && !class_o[3*t+2]); // R4
  end
endmodule

bind rof_flag_gen rof_flag_gen_chk #(.N(ETA_N*PHI_N)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .class_o (class_o),
  .flag_o  (flag_o),
  .done_o  (done_o)
);

// File: tb/rof_flag_gen_tb.sv
module rof_flag_gen_tb;
  localparam int ETA_N = 4;
  localparam int PHI_N = 8;
  localparam int EW    = 10;
  localparam int N     = ETA_N * PHI_N;
  localparam int NV    = 8;
  // {thr_lo, thr_hi, severe, seed}
  localparam int unsigned VEC [NV][4] = '{
    '{300, 700, 1, 3}, '{300, 700, 0, 7}, '{100, 900, 1, 11}, '{500, 500, 0, 19},
    '{0, 1023, 1, 23}, '{800, 1000, 0, 5}, '{200, 400, 1, 41}, '{600, 950, 1, 2}
  };

  logic clk_i = 0, rst_ni = 0, start_i = 0, severe_en_i = 0;
  logic [N*EW-1:0] energy_i = '0;
  logic [EW-1:0]   thr_lo_i = '0, thr_hi_i = '0;
  logic [N*3-1:0]  class_o;
  logic [N*2-1:0]  flag_o;
  logic            done_o;

  int n_vec = 0, n_bad = 0, cyc = 0;
  int e_arr [N];
  int x_cls [N];
  int x_flg [N];

  always #10 clk_i = ~clk_i;

  rof_flag_gen #(.ETA_N(ETA_N), .PHI_N(PHI_N), .EW(EW), .PHI_WRAP(1'b1)) u_dut (.*);

  task automatic model(input int lo, input int hi, input bit sev);
    for (int t = 0; t < N; t++) x_cls[t] = (e_arr[t] > hi) ? 2 : (e_arr[t] > lo) ? 1 : 0;
    for (int r = 0; r < ETA_N; r++) begin
      for (int c = 0; c < PHI_N; c++) begin
        bit hit = 0;
        for (int dr = -1; dr <= 1; dr++) begin
          for (int dc = -1; dc <= 1; dc++) begin
            int rr = r + dr;
            int cc = (c + dc + PHI_N) % PHI_N;
            if (rr >= 0 && rr < ETA_N && x_cls[rr*PHI_N+cc] == 2) hit = 1;
          end
        end
        x_flg[r*PHI_N+c] = hit ? 3 : (x_cls[r*PHI_N+c] == 1) ? 2 : sev ? 1 : 0;
      end
    end
  endtask

  task automatic compare(input string ftag);
    bit bad_c = 0, bad_f = 0;
    n_vec += 2;
    for (int t = 0; t < N; t++) begin
      if (!bad_c && int'(class_o[3*t +: 3]) != x_cls[t]) begin
        bad_c = 1;
        $display("FAIL %s tower %0d class got %0d exp %0d",
                 class_o[3*t+2] ? "R4" : x_cls[t] == 2 ? "R1" : x_cls[t] == 1 ? "R2" : "R3",
                 t, class_o[3*t +: 3], x_cls[t]);
      end
      if (!bad_f && int'(flag_o[2*t +: 2]) != x_flg[t]) begin
        bad_f = 1;
        $display("FAIL %s tower %0d flag got %0d exp %0d", ftag, t, flag_o[2*t +: 2], x_flg[t]);
      end
    end
    n_bad += int'(bad_c) + int'(bad_f);
  endtask

  task automatic run(input int lo, input int hi, input bit sev, input string ftag);
    model(lo, hi, sev);
    @(negedge clk_i);
    for (int t = 0; t < N; t++) energy_i[t*EW +: EW] = EW'(e_arr[t]);
    thr_lo_i = EW'(lo); thr_hi_i = EW'(hi); severe_en_i = sev; start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    @(negedge clk_i);
    n_vec++;
    if (done_o !== 1'b1) begin n_bad++; $display("FAIL R10 done got %b exp 1", done_o); end
    compare(ftag);
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 20000) begin
        n_bad++;
        $display("FAIL R10 watchdog got timeout exp completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10: reset state
    n_vec++;
    if (done_o !== 0 || class_o !== '0 || flag_o !== '0) begin
      n_bad++;
      $display("FAIL R10 reset got done=%b cls=%h flg=%h exp all zero", done_o, class_o, flag_o);
    end
    rst_ni = 1;

    for (int v = 0; v < NV; v++) begin
      for (int t = 0; t < N; t++)
        e_arr[t] = int'((VEC[v][3]*97 + t*t*13 + t*31 + VEC[v][3]*t*7) % 1024);
      run(int'(VEC[v][0]), int'(VEC[v][1]), VEC[v][2][0], "R5");
    end

    // R2 R3 R1 threshold equality
    for (int t = 0; t < N; t++) e_arr[t] = 100;
    e_arr[20] = 200; e_arr[21] = 201;
    run(100, 200, 1, "R6");

    // R8 R9 corner high tower, wrap in phi only
    for (int t = 0; t < N; t++) e_arr[t] = 0;
    e_arr[0] = 50;
    run(10, 20, 1, "R9");
    n_vec++;
    if (flag_o[2*(3*PHI_N) +: 2] !== 2'b01) begin
      n_bad++; $display("FAIL R8 last-row flag got %0d exp 1", flag_o[2*(3*PHI_N) +: 2]);
    end
    n_vec++;
    if (flag_o[2*(PHI_N+PHI_N-1) +: 2] !== 2'b11) begin
      n_bad++; $display("FAIL R9 wrap flag got %0d exp 3", flag_o[2*(PHI_N+PHI_N-1) +: 2]);
    end

    // R7 all-low with severity clear then set
    for (int t = 0; t < N; t++) e_arr[t] = 5;
    run(10, 20, 0, "R7");
    run(10, 20, 1, "R7");

    // R10 done pulse lasts one cycle
    @(negedge clk_i);
    n_vec++;
    if (done_o !== 1'b0) begin n_bad++; $display("FAIL R10 done width got %b exp 0", done_o); end

    // R11 inputs without strobe are ignored
    energy_i = '1; thr_lo_i = '0; thr_hi_i = '0; severe_en_i = 0;
    repeat (4) @(negedge clk_i);
    n_vec++;
    if (done_o !== 1'b0) begin n_bad++; $display("FAIL R11 done got %b exp 0", done_o); end
    compare("R11");

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule